// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is a real-time calendar counter. A single-cycle tick enable, nominally 32768 pulses per second, drives a sub-second prescaler. Each time the prescaler completes a full second, the packed-BCD time and date advance by one second. The seven kept fields are seconds, minutes, hours, day of month, month, a two-digit year (century 2000 implied) and weekday. Carries ripple from seconds to minutes, minutes to hours, hours to day, day to month and month to year. The day limit depends on the month and on the leap-year rule.

Software reaches the block over a flat byte bus. Writes are single-cycle and reads are combinational. The bus gives access to the seven time fields, a control byte with a run bit, and a status byte. The status byte shows the run state, a busy flag and four sticky rollover flags.

The busy flag rises a fixed number of ticks before each one-second update and drops on the tick that performs it. Software that sees busy low knows the time fields will hold still for that many ticks, so it can read a consistent time.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control byte reads 0x00 (stopped) and the status byte reads 0x00.
- R2: The time fields sit at byte addresses 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month), 0x14 (year) and 0x18 (weekday). A write keeps only the low 7 bits for seconds and minutes, the low 6 bits for hours and day, the low 5 bits for month and the low 3 bits for weekday, so the upper bits read as zero. The year keeps all 8 bits. Unmapped addresses read 0x00.
- R3: The control byte is at 0x40, and its bit 0 set to 1 lets the counter run. With bit 0 at 0, ticks change nothing. Status bit 1 (status at 0x44) mirrors the run bit.
- R4: While running, seconds advance by one in BCD every TICKS_PER_SEC ticks and wrap from 0x59 to 0x00.
- R5: A seconds wrap increments minutes, a minutes wrap at 0x59 increments hours, and an hours wrap from 0x23 to 0x00 increments the day.
- R6: The day wraps to 0x01 after 0x30 in months 04, 06, 09 and 11, and after 0x31 in the other months except February. Month wraps from 0x12 to 0x01 and increments the year.
- R7: February ends at 0x29 when the two-digit year value is divisible by 4, and at 0x28 otherwise.
- R8: The year wraps from 0x99 to 0x00.
- R9: The weekday increments on each day rollover and wraps from 6 to 0. It does not change on other updates.
- R10: Status bit 0 (busy) is 1 during the last BUSY_LEAD ticks before a one-second update and is 0 after it. Busy is never 1 while stopped.
- R11: Status bits 2, 3, 4 and 5 are sticky flags. They are set by a seconds update, a minutes increment, an hours increment and a day increment respectively. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R12: A write to any time field takes effect on the next cycle and restarts the prescaler, so the next update comes a full TICKS_PER_SEC ticks later. A write in the same cycle as an update wins, and that update is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle prescaler tick enable |
| busAddr | input | ADDR_W | Byte address for read and write |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |

## Verification
The bench builds the block with TICKS_PER_SEC = 4 and BUSY_LEAD = 1, so one second costs four ticks and the busy window is a single tick that can be probed exactly. At this size every month end in a leap and a non-leap year is reachable. So are the February end in all hundred years, the year wrap, and minute and hour carries, all well inside the cycle budget. The bench seeds each case by writing fields just short of a rollover and compares the result with a calendar computed arithmetically.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int IDX_W      = 3;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DAY   = 3;
  localparam int F_MONTH = 4;
  localparam int F_YEAR  = 5;
  localparam int F_WDAY  = 6;

  // Control to datapath strobes
  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] fieldWr;
    logic [7:0]            wrData;
  } calStrobe_t;

  // Datapath to control rollover events
  typedef struct packed {
    logic dayRoll;
    logic hourRoll;
    logic minRoll;
    logic secRoll;
  } calEvent_t;

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DAY:  return 8'h3F;
      F_MONTH:        return 8'h1F;
      F_WDAY:         return 8'h07;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fieldMin(input int idx);
    case (idx)
      F_DAY, F_MONTH: return 8'h01;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fieldMax(input int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h59;
      F_HOUR:         return 8'h23;
      F_DAY:          return 8'h31;
      F_MONTH:        return 8'h12;
      F_YEAR:         return 8'h99;
      default:        return 8'h06;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return v + 8'd1;
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] month,
                                           input logic [7:0] year);
    logic [7:0] yearBin;
    yearBin = 8'(year[7:4]) * 8'd10 + 8'(year[3:0]);
    case (month)
      8'h02:                     return (yearBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_clock_pkg::*;
#(
  parameter logic [7:0] MASK    = 8'hFF,
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       incEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic [7:0] maxVal,
  output logic [7:0] value,
  output logic       atMax
);

  assign atMax = (value >= maxVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= MIN_VAL;
    end else if (wrEn) begin
      value <= wrData & MASK;
    end else if (incEn) begin
      value <= atMax ? MIN_VAL : (bcdInc(value) & MASK);
    end
  end

endmodule

// File: rtl/cal_clock_datapath.sv
module cal_clock_datapath
  import cal_clock_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  calStrobe_t                  strobe,
  output logic [NUM_FIELDS-1:0][7:0]  fields,
  output calEvent_t                   events
);

  logic [NUM_FIELDS-1:0]      incVec;
  logic [NUM_FIELDS-1:0]      atMax;
  logic [NUM_FIELDS-1:0][7:0] maxVal;
  logic [7:0]                 dayLimit;

  assign dayLimit = monthDays(fields[F_MONTH], fields[F_YEAR]);

  // Carry chain: seconds -> minutes -> hours -> day -> month -> year,
  // weekday follows the day carry.
  always_comb begin
    incVec          = '0;
    incVec[F_SEC]   = strobe.advance;
    incVec[F_MIN]   = incVec[F_SEC]   & atMax[F_SEC];
    incVec[F_HOUR]  = incVec[F_MIN]   & atMax[F_MIN];
    incVec[F_DAY]   = incVec[F_HOUR]  & atMax[F_HOUR];
    incVec[F_MONTH] = incVec[F_DAY]   & atMax[F_DAY];
    incVec[F_YEAR]  = incVec[F_MONTH] & atMax[F_MONTH];
    incVec[F_WDAY]  = incVec[F_DAY];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gFields
    localparam logic [7:0] FMAX = fieldMax(i);
    if (i == F_DAY) begin : gDynLimit
      assign maxVal[i] = dayLimit;
    end else begin : gFixLimit
      assign maxVal[i] = FMAX;
    end

    cal_bcd_field #(
      .MASK    (fieldMask(i)),
      .MIN_VAL (fieldMin(i))
    ) uField (
      .clk    (clk),
      .rstN   (rstN),
      .incEn  (incVec[i]),
      .wrEn   (strobe.fieldWr[i]),
      .wrData (strobe.wrData),
      .maxVal (maxVal[i]),
      .value  (fields[i]),
      .atMax  (atMax[i])
    );
  end

  assign events.secRoll  = incVec[F_SEC];
  assign events.minRoll  = incVec[F_MIN];
  assign events.hourRoll = incVec[F_HOUR];
  assign events.dayRoll  = incVec[F_DAY];

endmodule

// File: rtl/cal_clock_ctrl.sv
module cal_clock_ctrl
  import cal_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_LEAD     = 8,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  calEvent_t         events,
  output calStrobe_t        strobe,
  output logic              runFlag,
  output logic              busyFlag,
  output logic [3:0]        eventFlags,
  output logic              timeSel,
  output logic [IDX_W-1:0]  fieldIdx,
  output logic              ctrlSel,
  output logic              statSel
);

  localparam int                 PRESC_W   = $clog2(TICKS_PER_SEC);
  localparam logic [PRESC_W-1:0] LAST      = PRESC_W'(TICKS_PER_SEC - 1);
  localparam logic [PRESC_W-1:0] BUSY_FROM = PRESC_W'(TICKS_PER_SEC - BUSY_LEAD);
  localparam logic [ADDR_W-1:0]  CTRL_ADDR = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0]  STAT_ADDR = ADDR_W'(8'h44);

  logic [PRESC_W-1:0] presc;
  logic               anyFieldWr;
  logic [3:0]         clearMask;
  logic [3:0]         setMask;

  // Address decode
  assign fieldIdx = busAddr[4:2];
  assign timeSel  = (busAddr[ADDR_W-1:5] == '0) && (busAddr[1:0] == 2'b00)
                    && (fieldIdx < IDX_W'(NUM_FIELDS));
  assign ctrlSel  = (busAddr == CTRL_ADDR);
  assign statSel  = (busAddr == STAT_ADDR);

  assign strobe.fieldWr = (busWrEn && timeSel) ? (NUM_FIELDS'(1) << fieldIdx) : '0;
  assign strobe.wrData  = busWrData;
  assign anyFieldWr     = |strobe.fieldWr;

  // A field write outranks the second update of the same cycle
  assign strobe.advance = runFlag && tickEn && (presc == LAST) && !anyFieldWr;
  assign busyFlag       = runFlag && (presc >= BUSY_FROM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
    end else if (anyFieldWr) begin
      presc <= '0;
    end else if (runFlag && tickEn) begin
      presc <= (presc == LAST) ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runFlag <= 1'b0;
    end else if (busWrEn && ctrlSel) begin
      runFlag <= busWrData[0];
    end
  end

  // Sticky flags: set beats clear when both land together
  assign clearMask = (busWrEn && statSel) ? busWrData[5:2] : 4'b0000;
  assign setMask   = {events.dayRoll, events.hourRoll, events.minRoll, events.secRoll};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventFlags <= 4'b0000;
    end else begin
      eventFlags <= (eventFlags & ~clearMask) | setMask;
    end
  end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_LEAD     = 8,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData
);

  calStrobe_t                 strobe;
  calEvent_t                  events;
  logic [NUM_FIELDS-1:0][7:0] fields;
  logic                       runFlag;
  logic                       busyFlag;
  logic [3:0]                 eventFlags;
  logic                       timeSel;
  logic [IDX_W-1:0]           fieldIdx;
  logic                       ctrlSel;
  logic                       statSel;

  cal_clock_ctrl #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .BUSY_LEAD     (BUSY_LEAD),
    .ADDR_W        (ADDR_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .events     (events),
    .strobe     (strobe),
    .runFlag    (runFlag),
    .busyFlag   (busyFlag),
    .eventFlags (eventFlags),
    .timeSel    (timeSel),
    .fieldIdx   (fieldIdx),
    .ctrlSel    (ctrlSel),
    .statSel    (statSel)
  );

  cal_clock_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .fields (fields),
    .events (events)
  );

  always_comb begin
    busRdData = 8'h00;
    if (timeSel) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (fieldIdx == IDX_W'(i)) busRdData = fields[i];
      end
    end else if (ctrlSel) begin
      busRdData = {7'b0, runFlag};
    end else if (statSel) begin
      busRdData = {2'b00, eventFlags, runFlag, busyFlag};
    end
  end

endmodule

// File: rtl/bcd_calendar_clock_checker.sv
module bcd_calendar_clock_checker
  import cal_clock_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       busWrEn,
  input logic [7:0]                 busWrData,
  input calStrobe_t                 strobe,
  input logic                       runFlag,
  input logic                       busyFlag,
  input logic [3:0]                 eventFlags,
  input logic [NUM_FIELDS-1:0][7:0] fields
);

  logic secClear;
  assign secClear = busWrEn && (busAddr == ADDR_W'(8'h44)) && busWrData[2];

  assert_busy_at_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> busyFlag);

  assert_busy_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> !busyFlag);

  assert_busy_needs_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> runFlag);

  assert_frozen_when_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runFlag && (strobe.fieldWr == '0)) |=> $stable(fields));

  assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fields[F_SEC][7] == 1'b0) && (fields[F_MIN][7] == 1'b0) &&
    (fields[F_HOUR][7:6] == 2'b00) && (fields[F_DAY][7:6] == 2'b00) &&
    (fields[F_MONTH][7:5] == 3'b000) && (fields[F_WDAY][7:3] == 5'b00000));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlags[0] && !secClear) |=> eventFlags[0]);

  assert_write_restarts_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fieldWr != '0) |=> !strobe.advance);

endmodule

bind bcd_calendar_clock bcd_calendar_clock_checker #(.ADDR_W(ADDR_W)) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .strobe     (strobe),
  .runFlag    (runFlag),
  .busyFlag   (busyFlag),
  .eventFlags (eventFlags),
  .fields     (fields)
);

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;

  localparam int TPS  = 4;
  localparam int LEAD = 1;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic [7:0] busAddr;
  logic       busWrEn;
  logic [7:0] busWrData;
  logic [7:0] busRdData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bcd_calendar_clock #(
    .TICKS_PER_SEC (TPS),
    .BUSY_LEAD     (LEAD),
    .ADDR_W        (8)
  ) uut (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int daysIn(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic chkReg(input string req, input logic [7:0] a, input logic [7:0] exp);
    busAddr = a;
    #1;
    check(req, busRdData, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic setTime(input int h, input int m, input int s, input int d,
                         input int mo, input int y, input int wd);
    wr(8'h14, bcd(y));
    wr(8'h10, bcd(mo));
    wr(8'h0C, bcd(d));
    wr(8'h18, bcd(wd));
    wr(8'h08, bcd(h));
    wr(8'h04, bcd(m));
    wr(8'h00, bcd(s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; busWrEn = 1'b0; busAddr = 8'h00; busWrData = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkReg("R1 sec",    8'h00, 8'h00);
    chkReg("R1 min",    8'h04, 8'h00);
    chkReg("R1 hour",   8'h08, 8'h00);
    chkReg("R1 day",    8'h0C, 8'h01);
    chkReg("R1 month",  8'h10, 8'h01);
    chkReg("R1 year",   8'h14, 8'h00);
    chkReg("R1 wday",   8'h18, 8'h00);
    chkReg("R1 ctrl",   8'h40, 8'h00);
    chkReg("R1 status", 8'h44, 8'h00);
    chkReg("R2 unmapped", 8'h1C, 8'h00);

    // R3 stopped: ticks have no effect
    ticks(12);
    chkReg("R3 stopped sec", 8'h00, 8'h00);
    chkReg("R3 stopped status", 8'h44, 8'h00);
    wr(8'h40, 8'h01);
    chkReg("R3 ctrl readback", 8'h40, 8'h01);
    chkReg("R3 status run", 8'h44, 8'h02);

    // R2 masking
    wr(8'h00, 8'hFF); chkReg("R2 sec mask",   8'h00, 8'h7F);
    wr(8'h04, 8'hFF); chkReg("R2 min mask",   8'h04, 8'h7F);
    wr(8'h08, 8'hFF); chkReg("R2 hour mask",  8'h08, 8'h3F);
    wr(8'h0C, 8'hFF); chkReg("R2 day mask",   8'h0C, 8'h3F);
    wr(8'h10, 8'hFF); chkReg("R2 month mask", 8'h10, 8'h1F);
    wr(8'h18, 8'hFF); chkReg("R2 wday mask",  8'h18, 8'h07);
    wr(8'h14, 8'h99); chkReg("R2 year full",  8'h14, 8'h99);

    // R10 busy window
    setTime(1, 2, 3, 10, 5, 21, 1);
    ticks(TPS - LEAD - 1);
    busAddr = 8'h44; #1; check("R10 busy low early", {7'b0, busRdData[0]}, 8'h00);
    chkReg("R10 sec held", 8'h00, 8'h03);
    ticks(1);
    busAddr = 8'h44; #1; check("R10 busy high before update", {7'b0, busRdData[0]}, 8'h01);
    chkReg("R10 sec before update", 8'h00, 8'h03);
    ticks(1);
    busAddr = 8'h44; #1; check("R10 busy low after update", {7'b0, busRdData[0]}, 8'h00);
    chkReg("R4 sec after update", 8'h00, 8'h04);

    // R11 sticky flags
    chkReg("R11 sec flag set", 8'h44, 8'h06);
    wr(8'h44, 8'h00); chkReg("R11 write zero no effect", 8'h44, 8'h06);
    wr(8'h44, 8'h04); chkReg("R11 clear sec flag", 8'h44, 8'h02);
    setTime(23, 59, 59, 3, 3, 21, 2);
    ticks(TPS);
    chkReg("R11 all flags", 8'h44, 8'h3E);
    wr(8'h44, 8'h08); chkReg("R11 clear min flag only", 8'h44, 8'h36);
    wr(8'h44, 8'h34); chkReg("R11 clear rest", 8'h44, 8'h02);

    // R12 write restarts prescaler
    setTime(5, 6, 7, 4, 4, 22, 3);
    ticks(TPS - 1);
    wr(8'h04, 8'h10);
    ticks(TPS - 1);
    chkReg("R12 no early update", 8'h00, 8'h07);
    chkReg("R12 minute written", 8'h04, 8'h10);
    ticks(1);
    chkReg("R12 update after full second", 8'h00, 8'h08);

    // R4 R5 seconds and minutes sweep
    setTime(0, 0, 0, 1, 1, 20, 0);
    for (int i = 1; i <= 125; i++) begin
      ticks(TPS);
      chkReg("R4 sweep sec", 8'h00, bcd(i % 60));
      chkReg("R5 sweep min", 8'h04, bcd(i / 60));
    end

    // R5 R9 hour and day carry
    setTime(23, 59, 59, 15, 6, 24, 2);
    ticks(TPS);
    chkReg("R5 hour wrap",  8'h08, 8'h00);
    chkReg("R5 min wrap",   8'h04, 8'h00);
    chkReg("R5 day inc",    8'h0C, 8'h16);
    chkReg("R9 wday inc",   8'h18, 8'h03);
    chkReg("R5 month held", 8'h10, 8'h06);
    setTime(10, 59, 59, 9, 9, 24, 6);
    ticks(TPS);
    chkReg("R5 hour inc",   8'h08, 8'h11);
    chkReg("R9 wday held",  8'h18, 8'h06);
    setTime(23, 59, 59, 9, 9, 24, 6);
    ticks(TPS);
    chkReg("R9 wday wrap",  8'h18, 8'h00);

    // R6 month ends in a common and a leap year
    for (int y = 23; y <= 24; y++) begin
      for (int m = 1; m <= 12; m++) begin
        setTime(23, 59, 59, daysIn(m, y) - 1, m, y, 0);
        ticks(TPS);
        chkReg("R6 day before end", 8'h0C, bcd(daysIn(m, y)));
        setTime(23, 59, 59, daysIn(m, y), m, y, 0);
        ticks(TPS);
        chkReg("R6 day wrap",   8'h0C, 8'h01);
        chkReg("R6 month next", 8'h10, bcd((m % 12) + 1));
        chkReg("R6 year",       8'h14, bcd((m == 12) ? y + 1 : y));
      end
    end

    // R7 February in every year
    for (int y = 0; y < 100; y++) begin
      setTime(23, 59, 59, 28, 2, y, 0);
      ticks(TPS);
      chkReg("R7 feb 28 next day",   8'h0C, (y % 4 == 0) ? 8'h29 : 8'h01);
      chkReg("R7 feb 28 next month", 8'h10, (y % 4 == 0) ? 8'h02 : 8'h03);
    end
    setTime(23, 59, 59, 29, 2, 96, 0);
    ticks(TPS);
    chkReg("R7 leap feb 29 wrap", 8'h10, 8'h03);

    // R8 year wrap
    setTime(23, 59, 59, 31, 12, 99, 4);
    ticks(TPS);
    chkReg("R8 year wrap",  8'h14, 8'h00);
    chkReg("R8 month wrap", 8'h10, 8'h01);
    chkReg("R8 day wrap",   8'h0C, 8'h01);
    chkReg("R9 wday after year", 8'h18, 8'h05);

    // R3 stop again freezes time
    wr(8'h40, 8'h00);
    ticks(3 * TPS);
    chkReg("R3 frozen sec", 8'h00, 8'h00);
    chkReg("R3 status stopped", 8'h44, {2'b00, 4'b1111, 2'b00});

    summary();
    $finish;
  end

endmodule